// File: doc/BRIEF.md
# Event Status/Enable and Slot Hotplug Register Block

This block holds the general-purpose event registers and the slot hotplug signalling registers of a platform power-management function. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time through a 4-byte event window. Status bits are cleared by writing ones. Enable bytes are replaced whole, and the other byte keeps its value. The event line `irq` is high while any enabled status bit is set.

A hotplug notification enters on a valid/ready input. It carries a slot number and an insert/remove flag. On acceptance the block wipes both slot bitmaps, marks the one slot in the "arrived" or "leaving" bitmap, sets status bit 1 and raises `irq` for a one-cycle pulse. Software reads the two 32-bit bitmaps through an 8-byte hotplug window. It acknowledges a removal by writing a one-hot slot mask to the eject register. The block turns the lowest set bit of that mask into a slot index and offers it on a valid/ready output, so the detach logic can take it.

Back-pressure rules: `hp_ready` is always high, so a notification is taken in every cycle that `hp_valid` is high. `ej_valid` and `ej_slot` hold steady until a cycle with `ej_ready` high. An eject write that arrives while an unaccepted indication is pending is dropped. A write in the same cycle as the acceptance loads the new one.

Top module: `gpe_hotplug_regs`

## Requirements
- R1: Register reads are one cycle late. `bus_rd` at an edge gives `bus_rvalid` high after that edge, with the value the register held before it. `bus_sel` codes are: 0 event window, 1 hotplug window, 2 eject register, 3 unmapped. Unmapped reads return 0 and unmapped writes change nothing. In the event window, `bus_addr[1]`=0 picks status and 1 picks enable. `bus_addr[0]`=1 picks bits 15:8 and 0 picks bits 7:0. The byte is returned on `bus_rdata[7:0]` and the upper bits are zero.
- R2: An event-window write to enable replaces only the selected byte with `bus_wdata[7:0]`. The other byte keeps its value.
- R3: An event-window write to status clears, in the selected byte only, the bits that are one in `bus_wdata[7:0]`. No other bit changes.
- R4: An accepted hotplug notification clears both bitmaps and then sets bit `hp_slot`. The bit goes in the arrived bitmap when `hp_insert`=1 and in the leaving bitmap when `hp_insert`=0. Hotplug-window reads return the arrived bitmap when `bus_addr[2]`=0 and the leaving bitmap when `bus_addr[2]`=1.
- R5: Every accepted notification sets status bit 1. If a status clear of that bit falls in the same cycle, the set wins.
- R6: `irq` is high for the cycle after each accepted notification. It is also high in every cycle where status AND enable is nonzero.
- R7: A nonzero write to the eject register raises `ej_valid` after that edge. `ej_slot` is the index of the lowest set bit of `bus_wdata`. Both hold until an edge with `ej_ready` high.
- R8: A zero write to the eject register raises no indication. Eject-register reads return 0. A nonzero eject write while `ej_valid` is high and `ej_ready` is low is dropped.
- R9: After reset, status, enable and both bitmaps read zero, and `irq`, `ej_valid` and `bus_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Window select (0 event, 1 hotplug, 2 eject, 3 unmapped) |
| bus_addr | input | 3 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid |
| hp_valid | input | 1 | Hotplug notification valid |
| hp_ready | output | 1 | Hotplug notification ready (constant high) |
| hp_slot | input | 5 | Slot number of the notification |
| hp_insert | input | 1 | 1 = slot arrived, 0 = slot leaving |
| irq | output | 1 | Event line: pulse plus enabled-status level |
| ej_valid | output | 1 | Removal indication valid |
| ej_ready | input | 1 | Removal indication taken |
| ej_slot | output | 5 | Slot index to detach |

## Verification
Two functions can hit the same register in one cycle. A hotplug notification can arrive in the cycle that software writes a one to status bit 1. An eject write can arrive while the previous indication is still waiting on `ej_ready`, or in the very cycle it is taken. The bench drives these collisions on purpose: `hp_valid` is raised together with a status clear, and eject writes are issued with `ej_ready` low and then high. A behavioural model applies the stated winner rules (set beats clear, a pending indication blocks a new one, acceptance frees the slot in the same edge). Its expected `irq`, eject output and read data are compared with the design on every clock.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;
  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_HP   = 2'd1,
    SEL_EJ   = 2'd2,
    SEL_NONE = 2'd3
  } bus_sel_e;

  localparam int HP_STS_BIT = 1;
endpackage

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
  parameter int EVT_W   = 16,
  parameter int SET_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             evt_set,
  output logic [EVT_W-1:0] sts,
  output logic [EVT_W-1:0] en
);
  localparam int LANES = EVT_W / 8;

  logic [EVT_W-1:0] sts_nxt, en_nxt, set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[SET_BIT] = evt_set;
    sts_nxt = sts;
    en_nxt  = en;
    for (int l = 0; l < LANES; l++) begin
      if (wr && (int'(addr[0]) == l)) begin
        if (addr[1]) en_nxt[l*8 +: 8] = wdata;
        else         sts_nxt[l*8 +: 8] = sts[l*8 +: 8] & ~wdata;
      end
    end
    sts_nxt = sts_nxt | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= sts_nxt;
      en  <= en_nxt;
    end
  end

  AST_EN_OTHER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'b10) |=> (en[15:8] == $past(en[15:8]))); // R2
  AST_STS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'b00 && !evt_set) |=> ((sts[7:0] & $past(wdata)) == 8'h00)); // R3
  AST_STS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> sts[SET_BIT]); // R5
endmodule

// File: rtl/gpe_slot_bitmaps.sv
module gpe_slot_bitmaps #(
  parameter int SLOTS = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [SLOT_W-1:0] slot,
  input  logic              insert,
  output logic [SLOTS-1:0]  up_map,
  output logic [SLOTS-1:0]  dn_map
);
  logic [SLOTS-1:0] one_hot;

  always_comb begin
    one_hot = '0;
    one_hot[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_map <= '0;
      dn_map <= '0;
    end else if (fire) begin
      up_map <= insert ? one_hot : '0;
      dn_map <= insert ? '0 : one_hot;
    end
  end

  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($countones({up_map, dn_map}) == 1)); // R4
endmodule

// File: rtl/gpe_eject_out.sv
module gpe_eject_out #(
  parameter int SLOTS = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SLOTS-1:0]  wdata,
  input  logic              ready,
  output logic              valid,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0] low_idx;
  logic              can_load;

  always_comb begin
    low_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (wdata[i]) low_idx = SLOT_W'(i);
    end
  end

  assign can_load = wr && (|wdata) && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      slot  <= '0;
    end else if (can_load) begin
      valid <= 1'b1;
      slot  <= low_idx;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_EJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(slot))); // R7
  AST_EJ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == '0 && !valid) |=> !valid); // R8
endmodule

// File: rtl/gpe_hotplug_regs.sv
module gpe_hotplug_regs
  import gpe_hp_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int EVT_W = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [2:0]        bus_addr,
  input  logic [SLOTS-1:0]  bus_wdata,
  output logic [SLOTS-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              hp_valid,
  output logic              hp_ready,
  input  logic [SLOT_W-1:0] hp_slot,
  input  logic              hp_insert,
  output logic              irq,
  output logic              ej_valid,
  input  logic              ej_ready,
  output logic [SLOT_W-1:0] ej_slot
);
  bus_sel_e         sel;
  logic             hp_fire, evt_wr, ej_wr, pulse_q;
  logic [EVT_W-1:0] sts, en, evt_reg;
  logic [SLOTS-1:0] up_map, dn_map, rd_mux;

  assign sel      = bus_sel_e'(bus_sel);
  assign hp_ready = 1'b1;
  assign hp_fire  = hp_valid && hp_ready;
  assign evt_wr   = bus_wr && (sel == SEL_EVT);
  assign ej_wr    = bus_wr && (sel == SEL_EJ);

  gpe_event_regs #(.EVT_W(EVT_W), .SET_BIT(HP_STS_BIT)) u_evt (
    .clk(clk), .rst_n(rst_n), .wr(evt_wr), .addr(bus_addr[1:0]),
    .wdata(bus_wdata[7:0]), .evt_set(hp_fire), .sts(sts), .en(en)
  );

  gpe_slot_bitmaps #(.SLOTS(SLOTS)) u_maps (
    .clk(clk), .rst_n(rst_n), .fire(hp_fire), .slot(hp_slot),
    .insert(hp_insert), .up_map(up_map), .dn_map(dn_map)
  );

  gpe_eject_out #(.SLOTS(SLOTS)) u_ej (
    .clk(clk), .rst_n(rst_n), .wr(ej_wr), .wdata(bus_wdata),
    .ready(ej_ready), .valid(ej_valid), .slot(ej_slot)
  );

  always_comb begin
    evt_reg = bus_addr[1] ? en : sts;
    rd_mux  = '0;
    case (sel)
      SEL_EVT: rd_mux[7:0] = bus_addr[0] ? evt_reg[15:8] : evt_reg[7:0];
      SEL_HP:  rd_mux      = bus_addr[2] ? dn_map : up_map;
      default: rd_mux      = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      pulse_q    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
      pulse_q    <= hp_fire;
    end
  end

  assign irq = pulse_q | (|(sts & en));

  AST_IRQ_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    hp_fire |=> irq); // R6
  AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & en)) |-> irq); // R6
endmodule

// File: tb/tb_gpe_hotplug_regs.sv
`timescale 1ns/1ps
module tb_gpe_hotplug_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0, hp_valid = 0, hp_insert = 0, ej_ready = 0;
  logic [1:0]  bus_sel = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [4:0]  hp_slot = 0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, hp_ready, irq, ej_valid;
  logic [4:0]  ej_slot;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpe_hotplug_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .hp_valid(hp_valid), .hp_ready(hp_ready),
    .hp_slot(hp_slot), .hp_insert(hp_insert), .irq(irq), .ej_valid(ej_valid),
    .ej_ready(ej_ready), .ej_slot(ej_slot)
  );

  // behavioural reference
  logic [15:0] m_sts, m_en;
  logic [31:0] m_up, m_dn, m_rdata;
  logic        m_pulse, m_ev, m_rv;
  logic [4:0]  m_eslot;

  function automatic logic [31:0] model_read(logic [1:0] s, logic [2:0] a);
    logic [15:0] r;
    r = a[1] ? m_en : m_sts;
    case (s)
      2'd0: return {24'h0, a[0] ? r[15:8] : r[7:0]};
      2'd1: return a[2] ? m_dn : m_up;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_up = 0; m_dn = 0; m_rdata = 0;
      m_pulse = 0; m_ev = 0; m_rv = 0; m_eslot = 0;
    end else begin
      logic [31:0] rd_now;
      logic        ev_busy;
      rd_now  = bus_rd ? model_read(bus_sel, bus_addr) : 32'h0;
      ev_busy = m_ev && !ej_ready;
      if (bus_wr && bus_sel == 2'd0) begin
        if (bus_addr[1]) begin
          if (bus_addr[0]) m_en[15:8] = bus_wdata[7:0]; else m_en[7:0] = bus_wdata[7:0];
        end else begin
          if (bus_addr[0]) m_sts[15:8] &= ~bus_wdata[7:0]; else m_sts[7:0] &= ~bus_wdata[7:0];
        end
      end
      if (hp_valid) begin
        m_up = 0; m_dn = 0;
        if (hp_insert) m_up[hp_slot] = 1'b1; else m_dn[hp_slot] = 1'b1;
        m_sts[1] = 1'b1;
      end
      m_pulse = hp_valid;
      if (m_ev && ej_ready) m_ev = 0;
      if (bus_wr && bus_sel == 2'd2 && bus_wdata != 0 && !ev_busy) begin
        m_ev = 1;
        for (int i = 31; i >= 0; i--) if (bus_wdata[i]) m_eslot = 5'(i);
      end
      m_rv = bus_rd;
      m_rdata = rd_now;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq", {31'h0, irq}, {31'h0, m_pulse | (|(m_sts & m_en))});
      check("R7 ej_valid", {31'h0, ej_valid}, {31'h0, m_ev});
      if (m_ev) check("R7 ej_slot", {27'h0, ej_slot}, {27'h0, m_eslot});
      check("R1 rvalid", {31'h0, bus_rvalid}, {31'h0, m_rv});
      if (m_rv) check("R1 rdata", bus_rdata, m_rdata);
      check("R4 hp_ready", {31'h0, hp_ready}, 32'h1);
    end
  end

  task automatic wr(logic [1:0] s, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_sel = s; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, logic [2:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1; bus_sel = s; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic hp(logic [4:0] s, logic ins);
    @(negedge clk);
    hp_valid = 1; hp_slot = s; hp_insert = ins;
    @(negedge clk);
    hp_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 irq", {31'h0, irq}, 32'h0);
    check("R9 ej_valid", {31'h0, ej_valid}, 32'h0);
    rd(2'd0, 3'd0, "R9 sts lo", 32'h0);
    rd(2'd0, 3'd3, "R9 en hi", 32'h0);
    rd(2'd1, 3'd0, "R9 up", 32'h0);
    rd(2'd1, 3'd4, "R9 down", 32'h0);

    wr(2'd0, 3'd2, 32'hFFFF_FFA5);
    wr(2'd0, 3'd3, 32'h0000_003C);
    rd(2'd0, 3'd2, "R2 en lo", 32'hA5);
    rd(2'd0, 3'd3, "R2 en hi", 32'h3C);
    wr(2'd0, 3'd2, 32'h0000_000D);
    rd(2'd0, 3'd3, "R2 en hi kept", 32'h3C);
    rd(2'd0, 3'd2, "R2 en lo new", 32'h0D);

    wr(2'd3, 3'd2, 32'hFF);
    rd(2'd0, 3'd2, "R1 unmapped write", 32'h0D);
    rd(2'd3, 3'd0, "R1 unmapped read", 32'h0);

    hp(5'd5, 1'b1);
    rd(2'd1, 3'd0, "R4 up slot5", 32'h0000_0020);
    rd(2'd1, 3'd4, "R4 down empty", 32'h0);
    rd(2'd0, 3'd0, "R5 sts bit1", 32'h02);
    wr(2'd0, 3'd2, 32'h02);
    check("R6 level irq", {31'h0, irq}, 32'h1);

    wr(2'd0, 3'd1, 32'hFF);
    rd(2'd0, 3'd0, "R3 other lane kept", 32'h02);
    wr(2'd0, 3'd0, 32'h02);
    rd(2'd0, 3'd0, "R3 cleared", 32'h0);
    check("R6 irq low", {31'h0, irq}, 32'h0);

    hp(5'd31, 1'b0);
    rd(2'd1, 3'd4, "R4 down slot31", 32'h8000_0000);
    rd(2'd1, 3'd0, "R4 up wiped", 32'h0);

    // collision: notification with status clear of bit 1
    @(negedge clk);
    hp_valid = 1; hp_slot = 0; hp_insert = 1;
    bus_wr = 1; bus_sel = 2'd0; bus_addr = 3'd0; bus_wdata = 32'h02;
    @(negedge clk);
    hp_valid = 0; bus_wr = 0;
    rd(2'd0, 3'd0, "R5 set beats clear", 32'h02);
    wr(2'd0, 3'd0, 32'h02);

    // pulse only when enable is off
    wr(2'd0, 3'd2, 32'h00);
    @(negedge clk);
    hp_valid = 1; hp_slot = 7; hp_insert = 1;
    @(negedge clk);
    hp_valid = 0;
    check("R6 pulse high", {31'h0, irq}, 32'h1);
    @(negedge clk);
    check("R6 pulse ends", {31'h0, irq}, 32'h0);

    // eject
    ej_ready = 0;
    wr(2'd2, 3'd0, 32'h0);
    check("R8 zero eject", {31'h0, ej_valid}, 32'h0);
    wr(2'd2, 3'd0, 32'h0000_00A0);
    check("R7 eject slot5", {27'h0, ej_slot}, 32'd5);
    wr(2'd2, 3'd0, 32'h0000_0001);
    check("R8 dropped while pending", {27'h0, ej_slot}, 32'd5);
    repeat (2) @(negedge clk);
    ej_ready = 1;
    @(negedge clk);
    check("R7 taken", {31'h0, ej_valid}, 32'h0);
    wr(2'd2, 3'd0, 32'h8000_0000);
    check("R7 eject slot31", {27'h0, ej_slot}, 32'd31);
    @(negedge clk);
    ej_ready = 0;
    wr(2'd2, 3'd0, 32'h0000_0001);
    check("R7 eject slot0", {27'h0, ej_slot}, 32'd0);
    @(negedge clk);
    // load in the same edge as acceptance
    ej_ready = 1; bus_wr = 1; bus_sel = 2'd2; bus_wdata = 32'h0001_0000;
    @(negedge clk);
    bus_wr = 0; ej_ready = 0;
    check("R7 reload on accept", {27'h0, ej_slot}, 32'd16);
    rd(2'd2, 3'd0, "R8 eject reads zero", 32'h0);
    ej_ready = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule